// File: doc/BRIEF.md
# Binary64 to Binary32 Narrowing Converter

This block takes one double-precision value and returns the nearest single-precision value under a rounding mode chosen per operation, together with the five IEEE exception flags. Finite values that fall outside the single-precision range either saturate or become infinity, depending on the rounding direction. Values that are very small come out as correctly rounded subnormals. Infinities and NaNs take their own paths, so they never pass through the rounding logic.

Operands are taken in with a valid/ready handshake. The result is registered and offered with its own valid/ready pair. The 32-bit result is placed in the low half of a 64-bit word, and the upper half is filled with ones, so a wide register file can hold it directly. A new operand can be accepted in the same cycle that the previous result leaves, which sustains one conversion per clock.

Top module: `narrow_f64_to_f32`

## Requirements
- R1: `in_ready` equals `!out_valid || out_ready`. An operand accepted on a clock edge appears on the outputs right after that edge. While `out_valid` is high and `out_ready` is low, the result and flags hold steady.
- R2: The upper 32 bits of `out_result` are always all ones whenever `out_valid` is high.
- R3: `in_rnd` selects the rounding mode: 000 ties-to-even, 001 toward zero, 010 toward negative, 011 toward positive, 100 ties-to-away. The codes 101 to 111 behave as ties-to-even. Finite results are rounded correctly, and inexact is raised whenever any discarded bit is nonzero.
- R4: An infinite input gives a binary32 infinity of the same sign (0x7F800000 or 0xFF800000) with no flags, in every rounding mode.
- R5: Any NaN input gives 0x7FC00000. A signalling NaN (mantissa bit 51 clear) raises invalid, and a quiet NaN raises nothing.
- R6: A finite input whose rounded magnitude reaches 2^128 raises overflow and inexact. The result is infinity, except that it is the largest finite value 0x7F7FFFFF (with sign) under toward-zero, under toward-negative for positive values, and under toward-positive for negative values.
- R7: Inputs below 2^-126 produce rounded binary32 subnormals. For example, 0x37B4C8F800000000 gives 0x0002991F with no flags.
- R8: Underflow is raised when the result is inexact and tiny after rounding. Tiny after rounding means below 2^-126 when rounded with an unbounded exponent. This includes the case where denormalized rounding carries up to 0x00800000 but the unbounded result stays below it. An exact subnormal result raises no underflow.
- R9: A zero input gives a zero of the same sign with no flags. A binary64 subnormal input rounds to zero or to the smallest subnormal, and raises underflow and inexact.
- R10: `out_flags` is {invalid, divide-by-zero, overflow, underflow, inexact}, from bit 4 down to bit 0. Divide-by-zero is always 0.
- R11: After a synchronous active-low reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Operand accepted when high together with in_valid |
| in_operand | input | 64 | Binary64 source value |
| in_rnd | input | 3 | Rounding mode code |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 64 | Binary32 result with the upper half set to ones |
| out_flags | output | 5 | Exception flags {NV, DZ, OF, UF, NX} |

## Verification
Draining a held result and accepting a new operand can happen on the same clock edge. The bench provokes this by holding `in_valid` high while `out_ready` toggles at random. It then judges every result against a queue in acceptance order, so a lost, duplicated or stale conversion shows up as a mismatch. Stalled cycles are checked for a stable result, and every acceptance must be followed by `out_valid` on the next cycle.

// File: rtl/narrow_pkg.sv
// Shared formats, rounding codes and flag layout for the narrowing converter.
// Assumes IEEE-style binary formats with a hidden leading one.
package narrow_pkg;
    localparam int SRC_W     = 64;
    localparam int SRC_EXP_W = 11;
    localparam int SRC_MAN_W = 52;
    localparam int DST_W     = 32;
    localparam int DST_EXP_W = 8;
    localparam int DST_MAN_W = 23;

    localparam int SRC_BIAS  = (1 << (SRC_EXP_W - 1)) - 1;
    localparam int DST_BIAS  = (1 << (DST_EXP_W - 1)) - 1;
    localparam int EXP_ADJ   = SRC_BIAS - DST_BIAS;
    localparam int SIG_W     = SRC_MAN_W + 1;
    localparam int KEEP_W    = DST_MAN_W + 1;
    localparam int DROP_W    = SIG_W - KEEP_W;
    localparam int PAD_W     = KEEP_W + 1;
    localparam int SH_W      = $clog2(PAD_W + 1);
    localparam int EB_W      = SRC_EXP_W + 2;
    localparam int FLAG_W    = 5;

    typedef enum logic [2:0] {
        RM_NEAR_EVEN = 3'd0,
        RM_ZERO      = 3'd1,
        RM_DOWN      = 3'd2,
        RM_UP        = 3'd3,
        RM_NEAR_AWAY = 3'd4
    } rnd_mode_e;

    typedef struct packed {
        logic nv;
        logic dz;
        logic of;
        logic uf;
        logic nx;
    } fp_flags_t;

    // Decide whether the kept significand is incremented by one unit.
    function automatic logic round_inc(logic [2:0] rm, logic sign, logic lsb,
                                       logic g, logic st);
        logic r;
        case (rm)
            RM_ZERO:      r = 1'b0;
            RM_DOWN:      r = sign & (g | st);
            RM_UP:        r = ~sign & (g | st);
            RM_NEAR_AWAY: r = g;
            default:      r = g & (st | lsb);
        endcase
        return r;
    endfunction
endpackage

// File: rtl/narrow_classify.sv
// Splits a binary64 operand into sign, class bits, significand and an exponent
// already rebiased to the binary32 bias. Purely combinational.
// Assumes binary64 subnormals only need to feed sticky information downstream.
module narrow_classify
    import narrow_pkg::*;
(
    input  logic [SRC_W-1:0]       op,
    output logic                   sign,
    output logic                   is_nan,
    output logic                   is_snan,
    output logic                   is_inf,
    output logic                   is_zero,
    output logic signed [EB_W-1:0] exp_unb,
    output logic [SIG_W-1:0]       sig
);
    logic [SRC_EXP_W-1:0] e;
    logic [SRC_MAN_W-1:0] m;

    // Field extraction and class decode.
    always_comb begin
        e       = op[SRC_W-2 -: SRC_EXP_W];
        m       = op[SRC_MAN_W-1:0];
        sign    = op[SRC_W-1];
        is_nan  = (&e) && (|m);
        is_snan = is_nan && !m[SRC_MAN_W-1];
        is_inf  = (&e) && !(|m);
        is_zero = !(|e) && !(|m);
        sig     = {|e, m};
        exp_unb = $signed({2'b00, e}) - $signed(EB_W'(EXP_ADJ));
    end
endmodule

// File: rtl/narrow_round.sv
// Rounds a finite nonzero significand into binary32 magnitude bits. It handles
// denormalization, carry into the exponent, overflow saturation and tininess
// after rounding. Assumes the caller filters NaN, infinity and zero.
module narrow_round
    import narrow_pkg::*;
(
    input  logic                   sign,
    input  logic [2:0]             rnd,
    input  logic signed [EB_W-1:0] exp_unb,
    input  logic [SIG_W-1:0]       sig,
    output logic [DST_W-2:0]       mag,
    output logic                   of,
    output logic                   uf,
    output logic                   nx
);
    localparam int WIDE_W  = SIG_W + PAD_W;
    localparam int MAX_EXP = (1 << DST_EXP_W) - 1;
    localparam logic [DST_W-2:0] MAX_FIN =
        {{(DST_EXP_W-1){1'b1}}, 1'b0, {DST_MAN_W{1'b1}}};
    localparam logic [DST_W-2:0] INF_MAG =
        {{DST_EXP_W{1'b1}}, {DST_MAN_W{1'b0}}};

    logic                   denorm;
    logic signed [EB_W-1:0] sh_full;
    logic [SH_W-1:0]        sh;
    logic [WIDE_W-1:0]      wide;
    logic [KEEP_W-1:0]      kept;
    logic                   g, st, inc, inc_u, carry_u;
    logic [KEEP_W:0]        rnd_sig;
    logic signed [EB_W-1:0] exp_fin;
    logic                   ovf, to_inf, tiny;

    // Alignment: shift right by the amount the result lies below the normal range.
    always_comb begin
        denorm  = (exp_unb <= 0);
        sh_full = $signed(EB_W'(1)) - exp_unb;
        if (!denorm)
            sh = '0;
        else if (sh_full > PAD_W)
            sh = SH_W'(PAD_W);
        else
            sh = sh_full[SH_W-1:0];
        wide = {sig, {PAD_W{1'b0}}} >> sh;
        kept = wide[WIDE_W-1 -: KEEP_W];
        g    = wide[WIDE_W-1-KEEP_W];
        st   = |wide[WIDE_W-2-KEEP_W:0];
    end

    // Increment decision and exponent after a possible carry.
    always_comb begin
        inc     = round_inc(rnd, sign, kept[0], g, st);
        rnd_sig = {1'b0, kept} + (KEEP_W+1)'(inc);
        exp_fin = exp_unb + $signed({{(EB_W-1){1'b0}}, rnd_sig[KEEP_W]});
        ovf     = !denorm && (exp_fin >= MAX_EXP);
    end

    // Overflow direction: infinity or the largest finite value.
    always_comb begin
        case (rnd)
            RM_ZERO: to_inf = 1'b0;
            RM_DOWN: to_inf = sign;
            RM_UP:   to_inf = ~sign;
            default: to_inf = 1'b1;
        endcase
    end

    // Tininess judged on the unbounded-exponent rounding of the raw significand.
    always_comb begin
        inc_u   = round_inc(rnd, sign, sig[DROP_W], sig[DROP_W-1], |sig[DROP_W-2:0]);
        carry_u = (&sig[SIG_W-1:DROP_W]) && inc_u;
        tiny    = denorm && !((exp_unb == 0) && carry_u);
    end

    // Output packing and flags.
    always_comb begin
        if (ovf)
            mag = to_inf ? INF_MAG : MAX_FIN;
        else if (denorm)
            mag = {{(DST_EXP_W-1){1'b0}}, rnd_sig[KEEP_W-1:0]};
        else
            mag = {exp_fin[DST_EXP_W-1:0], rnd_sig[DST_MAN_W-1:0]};
        of = ovf;
        nx = g | st | ovf;
        uf = tiny && (g | st);
    end
endmodule

// File: rtl/narrow_outreg.sv
// One-entry output register with a valid/ready pair on each side. It accepts
// new data in the same cycle the held entry drains. Data bits carry no reset.
module narrow_outreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] d,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] q
);
    // Space exists when empty or when the held entry leaves this cycle.
    assign in_ready = !out_valid || out_ready;

    // Occupancy flag.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_valid <= 1'b0;
        else if (in_ready)
            out_valid <= in_valid;
    end

    // Data capture on acceptance.
    always_ff @(posedge clk) begin
        if (in_valid && in_ready)
            q <= d;
    end

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(q))); // R1
endmodule

// File: rtl/narrow_f64_to_f32.sv
// Binary64 to binary32 converter. Classifies the operand, rounds finite
// values, substitutes NaN, infinity and zero results, and registers the
// boxed word and flags. Assumes in_rnd is stable while in_valid is high.
module narrow_f64_to_f32
    import narrow_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [SRC_W-1:0]  in_operand,
    input  logic [2:0]        in_rnd,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [SRC_W-1:0]  out_result,
    output logic [FLAG_W-1:0] out_flags
);
    localparam logic [DST_W-1:0] QNAN =
        {1'b0, {DST_EXP_W{1'b1}}, 1'b1, {(DST_MAN_W-1){1'b0}}};
    localparam logic [DST_W-2:0] INF_MAG =
        {{DST_EXP_W{1'b1}}, {DST_MAN_W{1'b0}}};

    logic                   sign, is_nan, is_snan, is_inf, is_zero;
    logic signed [EB_W-1:0] exp_unb;
    logic [SIG_W-1:0]       sig;
    logic [DST_W-2:0]       mag;
    logic                   r_of, r_uf, r_nx;
    logic [DST_W-1:0]       res32;
    fp_flags_t              flg;
    logic [SRC_W+FLAG_W-1:0] d_word, q_word;

    narrow_classify u_cls (
        .op      (in_operand),
        .sign    (sign),
        .is_nan  (is_nan),
        .is_snan (is_snan),
        .is_inf  (is_inf),
        .is_zero (is_zero),
        .exp_unb (exp_unb),
        .sig     (sig)
    );

    narrow_round u_rnd (
        .sign    (sign),
        .rnd     (in_rnd),
        .exp_unb (exp_unb),
        .sig     (sig),
        .mag     (mag),
        .of      (r_of),
        .uf      (r_uf),
        .nx      (r_nx)
    );

    // Special-value substitution and flag assembly.
    always_comb begin
        flg = '0;
        if (is_nan) begin
            res32  = QNAN;
            flg.nv = is_snan;
        end else if (is_inf) begin
            res32 = {sign, INF_MAG};
        end else if (is_zero) begin
            res32 = {sign, {(DST_W-1){1'b0}}};
        end else begin
            res32  = {sign, mag};
            flg.of = r_of;
            flg.uf = r_uf;
            flg.nx = r_nx;
        end
        d_word = {flg, {(SRC_W-DST_W){1'b1}}, res32};
    end

    narrow_outreg #(.W(SRC_W + FLAG_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .d         (d_word),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .q         (q_word)
    );

    assign out_result = q_word[SRC_W-1:0];
    assign out_flags  = q_word[SRC_W+FLAG_W-1:SRC_W];

    AST_BOXED: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (&out_result[SRC_W-1:DST_W])); // R2
    AST_INF_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && (&in_operand[SRC_W-2 -: SRC_EXP_W])
         && !(|in_operand[SRC_MAN_W-1:0]))
        |=> (out_result[DST_W-2:0] == INF_MAG
             && out_result[DST_W-1] == $past(in_operand[SRC_W-1]))); // R4
    AST_NAN_CANON: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && (&in_operand[SRC_W-2 -: SRC_EXP_W])
         && (|in_operand[SRC_MAN_W-1:0]))
        |=> (out_result[DST_W-1:0] == QNAN)); // R5
    AST_OF_INEXACT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_flags[2]) |-> out_flags[0]); // R6
    AST_UF_INEXACT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_flags[1]) |-> out_flags[0]); // R8
    AST_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !(|in_operand[SRC_W-2:0]))
        |=> (out_flags == '0 && out_result[DST_W-2:0] == '0)); // R9
    AST_NO_DZ: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !out_flags[3]); // R10
endmodule

// File: tb/tb_narrow_f64_to_f32.sv
module tb_narrow_f64_to_f32;
    localparam int ND = 24;
    localparam int NV = 3000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] in_operand = '0;
    logic [2:0]  in_rnd = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [63:0] out_result;
    logic [4:0]  out_flags;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    logic [63:0] v_op  [NV];
    logic [2:0]  v_rm  [NV];
    logic [36:0] v_exp [NV];

    always #10 clk = ~clk;

    narrow_f64_to_f32 dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_operand(in_operand), .in_rnd(in_rnd), .out_valid(out_valid),
        .out_ready(out_ready), .out_result(out_result), .out_flags(out_flags)
    );

    function automatic longint unsigned ref_div(longint unsigned sg, int drop,
                                                logic [2:0] rm, logic s, output bit inx);
        longint unsigned q, rem, half;
        bit up;
        if (drop >= 60) begin
            q = 0; inx = 1;
            up = (rm == 3'd3 && !s) || (rm == 3'd2 && s);
        end else begin
            q    = sg >> drop;
            rem  = sg & ((64'd1 << drop) - 1);
            half = 64'd1 << (drop - 1);
            inx  = (rem != 0);
            case (rm)
                3'd1:    up = 0;
                3'd2:    up = s && inx;
                3'd3:    up = !s && inx;
                3'd4:    up = (rem >= half);
                default: up = (rem > half) || (rem == half && q[0]);
            endcase
        end
        return q + (up ? 64'd1 : 64'd0);
    endfunction

    // Reference: {flags[4:0], result[31:0]} computed by integer quantum division.
    function automatic logic [36:0] ref_conv(logic [63:0] op, logic [2:0] rm);
        logic s;
        int e, eb, drop;
        longint unsigned sg, base, n, nu, bits;
        bit inx, inx_u, tiny, inf_dir;
        logic [51:0] m;
        s = op[63]; e = int'(op[62:52]); m = op[51:0];
        if (e == 2047) begin
            if (m != 0) return {(m[51] ? 5'b00000 : 5'b10000), 32'h7FC00000};
            return {5'b0, s, 31'h7F800000};
        end
        if (e == 0 && m == 0) return {5'b0, s, 31'h0};
        sg = {11'd0, (e != 0), m};
        eb = e - 896;
        if (eb >= 1) begin drop = 29; base = longint'(eb - 1) << 23; end
        else begin drop = 30 - eb; base = 0; end
        n = ref_div(sg, drop, rm, s, inx);
        bits = base + n;
        if (bits >= 64'h7F800000) begin
            case (rm)
                3'd1: inf_dir = 0;
                3'd2: inf_dir = s;
                3'd3: inf_dir = !s;
                default: inf_dir = 1;
            endcase
            return {5'b00101, s, (inf_dir ? 31'h7F800000 : 31'h7F7FFFFF)};
        end
        tiny = 0;
        if (eb <= 0) begin
            nu = ref_div(sg, 29, rm, s, inx_u);
            tiny = !(eb == 0 && nu == (64'd1 << 24));
        end
        return {3'b000, tiny && inx, inx, s, bits[30:0]};
    endfunction

    function automatic string tag_of(logic [63:0] op, logic [36:0] ex);
        if (&op[62:52]) return (op[51:0] != 0) ? "R5" : "R4";
        if (op[62:0] == 0) return "R9";
        if (ex[34]) return "R6";
        if (ex[33]) return "R8";
        if (op[62:52] == 0) return "R9";
        if (ex[30:23] == 0) return "R7";
        return "R3";
    endfunction

    task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp_v);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp_v);
        end
    endtask

    task automatic dir(int i, logic [63:0] op, logic [2:0] rm, logic [36:0] ex);
        v_op[i] = op; v_rm[i] = rm; v_exp[i] = ex;
    endtask

    initial begin
        int wr, rd;
        bit acc_prev, stall_prev;
        logic [63:0] held_r;
        logic [4:0]  held_f;
        void'($urandom(32'd20240611));
        // Directed corners with literal expectations.
        for (int k = 0; k < 5; k++) dir(k, 64'h7FF0000000000000, 3'(k), {5'b0, 32'h7F800000}); // R4 every mode
        dir(5,  64'hFFF0000000000000, 3'd3, {5'b0, 32'hFF800000});          // R4
        dir(6,  64'h7FF8000000000000, 3'd0, {5'b0, 32'h7FC00000});          // R5 quiet
        dir(7,  64'h7FF0000000000001, 3'd1, {5'b10000, 32'h7FC00000});      // R5 signalling
        dir(8,  64'h8000000000000000, 3'd2, {5'b0, 32'h80000000});          // R9
        dir(9,  64'h37B4C8F800000000, 3'd0, {5'b0, 32'h0002991F});          // R7 exact subnormal
        dir(10, 64'h47F0000000000000, 3'd1, {5'b00101, 32'h7F7FFFFF});      // R6 saturate
        dir(11, 64'h47F0000000000000, 3'd0, {5'b00101, 32'h7F800000});      // R6 to inf
        dir(12, 64'hC7F0000000000000, 3'd3, {5'b00101, 32'hFF7FFFFF});      // R6
        dir(13, 64'hC7F0000000000000, 3'd2, {5'b00101, 32'hFF800000});      // R6
        dir(14, 64'h380FFFFFE8000000, 3'd0, {5'b00011, 32'h00800000});      // R8 carry, still tiny
        dir(15, 64'h380FFFFFF0000000, 3'd0, {5'b00001, 32'h00800000});      // R8 carry, not tiny
        dir(16, 64'h0000000000000001, 3'd3, {5'b00011, 32'h00000001});      // R9 f64 subnormal
        dir(17, 64'h0000000000000001, 3'd0, {5'b00011, 32'h00000000});      // R9
        dir(18, 64'h3FF0000000000000, 3'd7, {5'b0, 32'h3F800000});          // R3 reserved code
        dir(19, 64'h3FF0000010000000, 3'd0, {5'b00001, 32'h3F800000});      // R3 tie to even
        dir(20, 64'h3FF0000010000000, 3'd4, {5'b00001, 32'h3F800001});      // R3 tie away
        dir(21, 64'h47EFFFFFF0000000, 3'd0, {5'b00101, 32'h7F800000});      // R6 round into overflow
        dir(22, 64'h0000000000000000, 3'd3, {5'b0, 32'h00000000});          // R9
        dir(23, 64'hBFF0000010000001, 3'd2, {5'b00001, 32'hBF800001});      // R3 toward negative
        for (int i = ND; i < NV; i++) begin
            logic [63:0] op;
            int sel;
            op  = {$urandom, $urandom};
            sel = int'($urandom % 10);
            if (sel < 6) op[62:52] = 11'(860 + ($urandom % 300));
            else if (sel == 6) op[62:52] = 11'h7FF;
            else if (sel == 7) op[62:52] = 11'h380;
            else if (sel == 8) op[62:52] = 11'h0;
            v_op[i] = op;
            v_rm[i] = 3'($urandom % 8);
            v_exp[i] = ref_conv(op, v_rm[i]);
        end

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0, "R11", "out_valid in reset", {63'd0, out_valid}, 64'd0);
        chk(in_ready == 1'b1, "R11", "in_ready in reset", {63'd0, in_ready}, 64'd1);
        rst_n = 1'b1;

        wr = 0; rd = 0; acc_prev = 0; stall_prev = 0;
        held_r = '0; held_f = '0;
        while (rd < NV) begin
            @(negedge clk);
            if (acc_prev)
                chk(out_valid, "R1", "valid after accept", {63'd0, out_valid}, 64'd1);
            if (stall_prev) begin
                chk(out_valid && out_result == held_r && out_flags == held_f,
                    "R1", "hold while stalled", out_result, held_r);
            end
            out_ready = ($urandom % 8) != 0;
            in_valid  = (wr < NV) && (($urandom % 8) != 0);
            if (wr < NV) begin
                in_operand = v_op[wr];
                in_rnd     = v_rm[wr];
            end
            #1;
            chk(in_ready == (!out_valid || out_ready), "R1", "in_ready rule",
                {63'd0, in_ready}, {63'd0, (!out_valid || out_ready)});
            if (out_valid && out_ready) begin
                chk(out_result[63:32] == 32'hFFFFFFFF, "R2", "boxing",
                    out_result, {32'hFFFFFFFF, out_result[31:0]});
                chk(out_flags[3] == 1'b0, "R10", "dz flag", {59'd0, out_flags}, 64'd0);
                chk(out_result[31:0] == v_exp[rd][31:0] && out_flags == v_exp[rd][36:32],
                    tag_of(v_op[rd], v_exp[rd]), $sformatf("op=%h rm=%0d", v_op[rd], v_rm[rd]),
                    {27'd0, out_flags, out_result[31:0]}, {27'd0, v_exp[rd]});
                rd++;
            end
            acc_prev = in_valid && in_ready;
            if (acc_prev) wr++;
            stall_prev = out_valid && !out_ready;
            held_r = out_result;
            held_f = out_flags;
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule